// File: doc/BRIEF.md
# Paged Digital I/O Controller with Edge Capture

This block is a byte-wide, register-mapped general-purpose I/O controller. It serves 48 lines, split into six 8-bit ports. A small bus, with an address, write data, registered read data and separate read and write strobes, reaches an 11-byte window. The six port registers drive the output lines. A page/lock register selects which bank appears at the three highest offsets, and it can also freeze individual ports. Those three offsets hold the edge-polarity, edge-enable or edge-capture bytes for the three lowest ports, depending on the page selected.

Every input line passes through a two-flop synchronizer. On ports 0 to 2, an enabled edge of the selected direction sets a sticky capture bit. Each port with a non-zero capture byte shows up in a pending summary byte, and any pending port holds the level interrupt output high. Software services an interrupt by reading the summary, switching to the capture page and reading the capture byte. It then writes zeros to release the bits.

Top module: `pdio_ctrl`

## Requirements
- R1: After reset all output lines are 0, `irq` is 0, `rdata` is 0x00, page 0 is selected and no port is locked.
- R2: A write to offset n (0 to 5) of an unlocked port drives `pin_out[8n+7:8n]` on the next clock. A read of that offset returns the written byte. Read data appears on `rdata` one clock after the cycle in which `rd_en` is high, and it holds its value otherwise.
- R3: Offset 7 is the page/lock register. Bits 7:6 select page 0 to 3, and bit n (5:0) locks port n. A write to a locked port has no effect on `pin_out`, and a read of a locked port returns its synchronized input lines.
- R4: On page 1, offsets 8, 9 and 10 take the polarity bytes of ports 0, 1 and 2. A polarity bit of 1 captures rising edges of its line and a polarity bit of 0 captures falling edges.
- R5: On page 2, offsets 8 to 10 take the edge-enable bytes of ports 0 to 2. An edge on a line whose enable bit is 0 captures nothing.
- R6: On page 3, offsets 8 to 10 read the capture bytes of ports 0 to 2. A qualifying input change that is applied between clock edges is visible on `irq` after the third following rising edge, and not after the second.
- R7: A write to a capture byte on page 3 clears every bit written as 0 and keeps every bit written as 1, so writing 0x00 clears the whole port. Captured bits otherwise stay set.
- R8: Offset 6 reads the pending summary on every page. Bit n (2:0) is 1 while capture byte n is non-zero, and bits 7:3 read 0.
- R9: `irq` is 1 exactly while any capture bit is set, and it stays a level until the bits are cleared.
- R10: Reads of offset 7, of offsets 8 to 10 on pages 0, 1 and 2, and of offsets 11 to 15 return 0x00.
- R11: Writes to offsets 8 to 10 while page 0 is selected, and writes to offset 6, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Asynchronous input lines |
| pin_out | output | 48 | Output latches of the six ports |
| irq | output | 1 | Level interrupt, high while any edge is captured |

## Verification
Port writes use the bytes 0xA5, 0x5A, 0xFF and a distinct byte per port. These expose swapped byte lanes and stuck bits. Edges are applied in both directions, under both polarity settings, and with the enable bit on and off, so that the bench can tell a direction error from a gating error. A single-bit rise on port 0 is timed to the cycle, which distinguishes a missing or extra synchronizer stage. A falling edge on the top bit of port 2 checks the highest bank and the highest pending bit. Two bits captured together and then cleared by a partial write separate mask-clearing from a full clear. Page 0 writes and writes to the summary offset are followed by edges on port 1, so that a mis-decoded bank would appear as a capture.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    PAGE_BASE = 2'd0,
    PAGE_POL  = 2'd1,
    PAGE_ENAB = 2'd2,
    PAGE_CAPT = 2'd3
  } page_e;
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
  parameter int WIDTH  = 48,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pdio_regs.sv
module pdio_regs
  import pdio_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int EDGE_PORTS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [NUM_PORTS*BYTE_W-1:0]  out_flat,
  output page_e                        page,
  output logic [NUM_PORTS-1:0]         lock,
  output logic [EDGE_PORTS*BYTE_W-1:0] pol_flat,
  output logic [EDGE_PORTS*BYTE_W-1:0] enab_flat,
  output logic [EDGE_PORTS-1:0]        capt_clr
);
  localparam int PGLK_OFF = NUM_PORTS + 1;
  localparam int BANK_OFF = NUM_PORTS + 2;

  logic [NUM_PORTS*BYTE_W-1:0]  out_q, out_d;
  page_e                        page_q, page_d;
  logic [NUM_PORTS-1:0]         lock_q, lock_d;
  logic [EDGE_PORTS*BYTE_W-1:0] pol_q, pol_d, enab_q, enab_d;

  always_comb begin
    out_d    = out_q;
    page_d   = page_q;
    lock_d   = lock_q;
    pol_d    = pol_q;
    enab_d   = enab_q;
    capt_clr = '0;
    if (wr_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr == ADDR_W'(p) && !lock_q[p]) out_d[p*BYTE_W +: BYTE_W] = wdata;
      end
      if (addr == ADDR_W'(PGLK_OFF)) begin
        page_d = page_e'(wdata[7:6]);
        lock_d = wdata[NUM_PORTS-1:0];
      end
      for (int b = 0; b < EDGE_PORTS; b++) begin
        if (addr == ADDR_W'(BANK_OFF + b)) begin
          case (page_q)
            PAGE_POL:  pol_d[b*BYTE_W +: BYTE_W]  = wdata;
            PAGE_ENAB: enab_d[b*BYTE_W +: BYTE_W] = wdata;
            PAGE_CAPT: capt_clr[b]                = 1'b1;
            default:   ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      page_q <= PAGE_BASE;
      lock_q <= '0;
      pol_q  <= '0;
      enab_q <= '0;
    end else if (wr_en) begin
      out_q  <= out_d;
      page_q <= page_d;
      lock_q <= lock_d;
      pol_q  <= pol_d;
      enab_q <= enab_d;
    end
  end

  assign out_flat  = out_q;
  assign page      = page_q;
  assign lock      = lock_q;
  assign pol_flat  = pol_q;
  assign enab_flat = enab_q;
endmodule

// File: rtl/pdio_edge_bank.sv
module pdio_edge_bank
  import pdio_pkg::*;
#(
  parameter int EDGE_PORTS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [EDGE_PORTS*BYTE_W-1:0] line_sync,
  input  logic [EDGE_PORTS*BYTE_W-1:0] pol_flat,
  input  logic [EDGE_PORTS*BYTE_W-1:0] enab_flat,
  input  logic [EDGE_PORTS-1:0]        capt_clr,
  input  logic [BYTE_W-1:0]            clr_mask,
  output logic [EDGE_PORTS*BYTE_W-1:0] capt_flat,
  output logic [EDGE_PORTS-1:0]        pending
);
  for (genvar g = 0; g < EDGE_PORTS; g++) begin : g_port
    logic [BYTE_W-1:0] cur, prev_q, capt_q, capt_d, pol, enab, hit;

    assign cur  = line_sync[g*BYTE_W +: BYTE_W];
    assign pol  = pol_flat[g*BYTE_W +: BYTE_W];
    assign enab = enab_flat[g*BYTE_W +: BYTE_W];

    always_comb begin
      hit    = enab & ((pol & cur & ~prev_q) | (~pol & ~cur & prev_q));
      capt_d = (capt_clr[g] ? (capt_q & clr_mask) : capt_q) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        capt_q <= '0;
      end else begin
        prev_q <= cur;
        capt_q <= capt_d;
      end
    end

    assign capt_flat[g*BYTE_W +: BYTE_W] = capt_q;
    assign pending[g] = |capt_q;
  end
endmodule

// File: rtl/pdio_rdmux.sv
module pdio_rdmux
  import pdio_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int EDGE_PORTS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  page_e                        page,
  input  logic [NUM_PORTS-1:0]         lock,
  input  logic [NUM_PORTS*BYTE_W-1:0]  out_flat,
  input  logic [NUM_PORTS*BYTE_W-1:0]  pin_sync,
  input  logic [EDGE_PORTS-1:0]        pending,
  input  logic [EDGE_PORTS*BYTE_W-1:0] capt_flat,
  output logic [BYTE_W-1:0]            rdata
);
  localparam int PEND_OFF = NUM_PORTS;
  localparam int BANK_OFF = NUM_PORTS + 2;

  logic [BYTE_W-1:0] sel, rdata_q;

  always_comb begin
    sel = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(p))
        sel = lock[p] ? pin_sync[p*BYTE_W +: BYTE_W] : out_flat[p*BYTE_W +: BYTE_W];
    end
    if (addr == ADDR_W'(PEND_OFF)) sel = {{(BYTE_W-EDGE_PORTS){1'b0}}, pending};
    for (int b = 0; b < EDGE_PORTS; b++) begin
      if (addr == ADDR_W'(BANK_OFF + b) && page == PAGE_CAPT)
        sel = capt_flat[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= sel;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pdio_ctrl.sv
module pdio_ctrl
  import pdio_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int EDGE_PORTS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        wr_en,
  input  logic                        rd_en,
  output logic [BYTE_W-1:0]           rdata,
  input  logic [NUM_PORTS*BYTE_W-1:0] pin_in,
  output logic [NUM_PORTS*BYTE_W-1:0] pin_out,
  output logic                        irq
);
  localparam int LINES      = NUM_PORTS * BYTE_W;
  localparam int EDGE_LINES = EDGE_PORTS * BYTE_W;

  logic [LINES-1:0]      pin_sync, out_flat;
  page_e                 page_q;
  logic [NUM_PORTS-1:0]  lock_q;
  logic [EDGE_LINES-1:0] pol_flat, enab_flat, capt_flat;
  logic [EDGE_PORTS-1:0] capt_clr, pending;

  pdio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  pdio_regs #(.NUM_PORTS(NUM_PORTS), .EDGE_PORTS(EDGE_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .out_flat(out_flat), .page(page_q), .lock(lock_q),
    .pol_flat(pol_flat), .enab_flat(enab_flat), .capt_clr(capt_clr)
  );

  pdio_edge_bank #(.EDGE_PORTS(EDGE_PORTS)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_sync(pin_sync[EDGE_LINES-1:0]),
    .pol_flat(pol_flat), .enab_flat(enab_flat), .capt_clr(capt_clr),
    .clr_mask(wdata), .capt_flat(capt_flat), .pending(pending)
  );

  pdio_rdmux #(.NUM_PORTS(NUM_PORTS), .EDGE_PORTS(EDGE_PORTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .page(page_q),
    .lock(lock_q), .out_flat(out_flat), .pin_sync(pin_sync),
    .pending(pending), .capt_flat(capt_flat), .rdata(rdata)
  );

  assign pin_out = out_flat;
  assign irq     = |pending;
endmodule

// File: rtl/pdio_ctrl_chk.sv
module pdio_ctrl_chk
  import pdio_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int EDGE_PORTS = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            addr,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [BYTE_W-1:0]            rdata,
  input logic [NUM_PORTS*BYTE_W-1:0]  pin_out,
  input logic                         irq,
  input page_e                        page,
  input logic [NUM_PORTS-1:0]         lock,
  input logic [EDGE_PORTS*BYTE_W-1:0] capt_flat,
  input logic [EDGE_PORTS*BYTE_W-1:0] enab_flat
);
  localparam int BANK_OFF = NUM_PORTS + 2;

  logic locked_port_wr, capt_wr;
  always_comb begin
    locked_port_wr = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (wr_en && addr == ADDR_W'(p) && lock[p]) locked_port_wr = 1'b1;
    capt_wr = wr_en && page == PAGE_CAPT &&
              addr >= ADDR_W'(BANK_OFF) && addr < ADDR_W'(BANK_OFF + EDGE_PORTS);
  end

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_port_wr |=> $stable(pin_out));

  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((capt_flat & ~$past(capt_flat)) & ~$past(enab_flat)) == '0);

  p_capture_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capt_wr |=> ((capt_flat & $past(capt_flat)) == $past(capt_flat)));

  p_summary_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(NUM_PORTS)) |=> rdata[BYTE_W-1:EDGE_PORTS] == '0);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (capt_flat != '0));
endmodule

bind pdio_ctrl pdio_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .EDGE_PORTS(EDGE_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .pin_out(pin_out), .irq(irq), .page(page_q), .lock(lock_q),
  .capt_flat(capt_flat), .enab_flat(enab_flat)
);

// File: tb/pdio_ctrl_test.sv
module pdio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pin_out", pin_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", rdata, 0);
    rd(4'd0, d);
    chk("R1 port0 read", d, 0);
  endtask

  task automatic t_ports;
    logic [7:0] d;
    logic [47:0] exp = '0;
    for (int p = 0; p < 6; p++) begin
      wr(4'(p), 8'(8'h13 * (p + 1)));
      exp[p*8 +: 8] = 8'(8'h13 * (p + 1));
    end
    chk("R2 all ports", pin_out, exp);
    for (int p = 0; p < 6; p++) begin
      rd(4'(p), d);
      chk("R2 readback", d, 8'(8'h13 * (p + 1)));
    end
    wr(4'd2, 8'hA5); rd(4'd2, d); chk("R2 A5", d, 8'hA5);
    wr(4'd4, 8'h5A); rd(4'd4, d); chk("R2 5A", d, 8'h5A);
    wr(4'd5, 8'hFF); chk("R2 FF lane", pin_out[47:40], 8'hFF);
    idle(2);
    chk("R2 rdata holds", rdata, 8'h5A);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    pin_in[15:8] = 8'h3C;
    wr(4'd1, 8'h11);
    wr(4'd7, 8'h02);
    wr(4'd1, 8'h77);
    chk("R3 locked write", pin_out[15:8], 8'h11);
    rd(4'd1, d);
    chk("R3 locked read pins", d, 8'h3C);
    wr(4'd7, 8'h00);
    wr(4'd1, 8'h77);
    chk("R3 unlocked write", pin_out[15:8], 8'h77);
    pin_in[15:8] = 8'h00;
    wr(4'd1, 8'h00);
  endtask

  task automatic t_zero_reads;
    logic [7:0] d;
    rd(4'd7, d); chk("R10 pagelock read", d, 0);
    wr(4'd7, 8'h40); wr(4'd8, 8'hFF); rd(4'd8, d); chk("R10 pol read", d, 0);
    wr(4'd8, 8'h00);
    wr(4'd7, 8'h80); wr(4'd9, 8'hFF); rd(4'd9, d); chk("R10 enab read", d, 0);
    wr(4'd9, 8'h00);
    wr(4'd7, 8'h00); rd(4'd10, d); chk("R10 page0 bank read", d, 0);
    rd(4'd11, d); chk("R10 off11", d, 0);
    rd(4'd15, d); chk("R10 off15", d, 0);
  endtask

  task automatic t_page0_ignored;
    logic [7:0] d;
    wr(4'd7, 8'h00);
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF); wr(4'd6, 8'hFF);
    wr(4'd7, 8'h40); wr(4'd9, 8'hFF);
    pin_in[15:8] = 8'hFF;
    idle(5);
    chk("R11 no capture port1", irq, 0);
    rd(4'd6, d);
    chk("R11 summary", d, 0);
    pin_in[15:8] = 8'h00;
    idle(5);
    chk("R5 disabled edges", irq, 0);
    wr(4'd9, 8'h00);
  endtask

  task automatic t_rise_timing;
    logic [7:0] d;
    wr(4'd7, 8'h40); wr(4'd8, 8'h01);
    wr(4'd7, 8'h80); wr(4'd8, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 not after two edges", irq, 0);
    @(negedge clk);
    chk("R6 irq after three edges", irq, 1);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); chk("R6 capture read", d, 8'h01);
    rd(4'd6, d); chk("R8 summary port0", d, 8'h01);
    idle(3);
    chk("R9 level holds", irq, 1);
    wr(4'd8, 8'h00);
    chk("R7 cleared", irq, 0);
    pin_in[0] = 1'b0;
    idle(5);
    chk("R4 falling ignored under rising", irq, 0);
  endtask

  task automatic t_fall_port2;
    logic [7:0] d;
    wr(4'd7, 8'h40); wr(4'd10, 8'h00);
    wr(4'd7, 8'h80); wr(4'd10, 8'h80);
    pin_in[23] = 1'b1;
    idle(5);
    chk("R4 rising ignored under falling", irq, 0);
    pin_in[23] = 1'b0;
    idle(4);
    chk("R4 falling captured", irq, 1);
    wr(4'd7, 8'hC0);
    rd(4'd10, d); chk("R6 port2 capture", d, 8'h80);
    rd(4'd6, d); chk("R8 summary port2", d, 8'h04);
    wr(4'd10, 8'h00);
    rd(4'd6, d); chk("R7 summary cleared", d, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_partial_clear;
    logic [7:0] d;
    wr(4'd7, 8'h40); wr(4'd8, 8'h06);
    wr(4'd7, 8'h80); wr(4'd8, 8'h06);
    pin_in[2:1] = 2'b11;
    idle(4);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); chk("R6 two bits", d, 8'h06);
    wr(4'd8, 8'h02);
    rd(4'd8, d); chk("R7 partial clear", d, 8'h02);
    chk("R9 still pending", irq, 1);
    wr(4'd8, 8'h00);
    chk("R7 full clear", irq, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_ports();
    t_lock();
    t_zero_reads();
    t_page0_ignored();
    t_rise_timing();
    t_fall_port2();
    t_partial_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule